// File: doc/BRIEF.md
# Horizontal Chroma Resampler, 4:4:4 to 4:2:2

This block takes a stream of pixels that each carry a full luma sample and both chroma samples. It emits one 16-bit word per pixel. Luma goes through at full rate. Chroma is halved horizontally: for each pixel pair, one blue-difference and one red-difference sample are kept. Each kept sample is the output of a three-tap smoothing filter with weights one quarter, one half and one quarter, centred on the even pixel of the pair. This limits aliasing compared with simply dropping every second sample.

The word for an even pixel carries its luma in the low byte and the pair's filtered blue-difference sample in the high byte. The word for the following odd pixel carries its own luma and the pair's filtered red-difference sample. Both streams use a valid/ready handshake, with a start-of-frame flag on the first pixel of a frame and an end-of-line flag on the last pixel of each line. Lines hold an even number of pixels.

The block sits between a colour-space converter and a frame-buffer writer. It accepts one pixel per cycle when the sink is always ready, and backpressure stalls it without losing any sample.

Top module: `chroma422_resampler`

## Requirements
- R1: Each accepted input pixel produces exactly one output word, in input order. The word's low byte is that pixel's luma, unchanged.
- R2: Number the pixels of a line from 0, so that pair k holds pixels 2k and 2k+1. The high byte of the word for pixel 2k is (Cb[2k-1] + 2*Cb[2k] + Cb[2k+1] + 2) >> 2. The high byte of the word for pixel 2k+1 is the same formula applied to Cr.
- R3: For the first pair of a line, the missing left neighbour is replaced by the sample of pixel 0 itself. No filter input reaches back into the previous line.
- R4: The chroma phase restarts at every line: the first word of each line carries Cb, and words alternate Cb, Cr from there.
- R5: A pair with flat chroma 0x52 and luma 0xF0 then 0x5A produces the words 0x52F0 then 0x525A. Constant chroma of 0x00 or 0xFF passes through exactly, with no overflow.
- R6: out_sof is set only on the first word of a frame. out_eol is set only on the odd word of the last pair of a line.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_sof and out_eol hold their values.
- R8: During and right after reset, out_valid is low and in_ready is high.
- R9: The first word of a pair is valid in the cycle after the pair's odd pixel is accepted. When out_ready is held high, in_ready stays high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink accepts the output word |
| out_data | output | 16 | Chroma in bits 15:8, luma in bits 7:0 |
| out_sof | output | 1 | First word of a frame |
| out_eol | output | 1 | Last word of a line |

## Verification
The assertions assume that every line has an even number of pixels. They also assume that in_eol never falls on an even pixel and that in_sof only marks the first pixel of a line. The bench draws line widths only from even values between 2 and 32 and raises in_sof only on the first pixel of a frame's first line, so the stimulus never breaks these assumptions. It also holds each input stable until it is accepted, which the no-loss property relies on. Random idle gaps on the input and random stalls on out_ready exercise backpressure. Directed lines cover the two-pixel line, flat colour, and the extreme chroma values.

// File: rtl/chroma422_pkg.sv
`timescale 1ns/1ps
package chroma422_pkg;
    parameter int unsigned PIX_W = 8;
    localparam int unsigned WORD_W = 2 * PIX_W;
    localparam int unsigned ACC_W  = PIX_W + 2;

    typedef logic [PIX_W-1:0] samp_t;

    typedef struct packed {
        samp_t y;
        samp_t cb;
        samp_t cr;
    } pix_t;

    typedef struct packed {
        samp_t c;
        samp_t y;
    } word_t;

    typedef struct packed {
        word_t w;
        logic  sof;
        logic  eol;
    } beat_t;

    typedef struct packed {
        samp_t y_even;
        samp_t y_odd;
        samp_t cb_f;
        samp_t cr_f;
        logic  sof;
        logic  eol;
    } pair_t;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_FIRST,
        PK_SECOND
    } pk_state_e;

    // Quarter-half-quarter smoothing with round-half-up.
    function automatic samp_t tap3(samp_t l, samp_t m, samp_t r);
        logic [ACC_W-1:0] acc;
        acc = ACC_W'(l) + (ACC_W'(m) << 1) + ACC_W'(r) + ACC_W'(2);
        return acc[ACC_W-1:2];
    endfunction
endpackage

// File: rtl/c422_pair_gather.sv
`timescale 1ns/1ps
module c422_pair_gather
    import chroma422_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  pix_t  in_pix,
    input  logic  in_sof,
    input  logic  in_eol,
    output logic  pair_valid,
    input  logic  pair_ready,
    output pair_t pair
);
    pix_t  even_q;
    logic  even_v;
    logic  even_sof;
    logic  even_first;
    logic  line_start;
    samp_t prev_cb;
    samp_t prev_cr;
    samp_t left_cb;
    samp_t left_cr;
    logic  take_even;
    logic  take_pair;

    assign pair_valid = even_v && in_valid;
    assign in_ready   = !even_v || pair_ready;
    assign take_even  = !even_v && in_valid;
    assign take_pair  = pair_valid && pair_ready;

    // Edge replication on the first pair of a line.
    assign left_cb = even_first ? even_q.cb : prev_cb;
    assign left_cr = even_first ? even_q.cr : prev_cr;

    always_comb begin
        pair.y_even = even_q.y;
        pair.y_odd  = in_pix.y;
        pair.cb_f   = tap3(left_cb, even_q.cb, in_pix.cb);
        pair.cr_f   = tap3(left_cr, even_q.cr, in_pix.cr);
        pair.sof    = even_sof;
        pair.eol    = in_eol;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            even_q     <= '0;
            even_v     <= 1'b0;
            even_sof   <= 1'b0;
            even_first <= 1'b0;
            line_start <= 1'b1;
            prev_cb    <= '0;
            prev_cr    <= '0;
        end else if (take_even) begin
            even_q     <= in_pix;
            even_v     <= 1'b1;
            even_sof   <= in_sof;
            even_first <= line_start || in_sof;
        end else if (take_pair) begin
            even_v     <= 1'b0;
            prev_cb    <= in_pix.cb;
            prev_cr    <= in_pix.cr;
            line_start <= in_eol;
        end
    end

    // R7
    even_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (even_v && !take_pair) |=> (even_v && $stable(even_q)));
endmodule

// File: rtl/c422_pair_pack.sv
`timescale 1ns/1ps
module c422_pair_pack
    import chroma422_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pair_valid,
    output logic               pair_ready,
    input  pair_t              pair,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_sof,
    output logic               out_eol
);
    pk_state_e st;
    beat_t     slot [2];
    beat_t     cur;
    logic      load;
    logic      in_second;

    assign in_second  = (st == PK_SECOND);
    assign pair_ready = (st == PK_IDLE) || (in_second && out_ready);
    assign load       = pair_valid && pair_ready;
    assign cur        = in_second ? slot[1] : slot[0];
    assign out_valid  = (st != PK_IDLE);
    assign out_data   = cur.w;
    assign out_sof    = cur.sof;
    assign out_eol    = cur.eol;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PK_IDLE;
            slot[0] <= '0;
            slot[1] <= '0;
        end else begin
            if (load) begin
                slot[0] <= '{w: '{c: pair.cb_f, y: pair.y_even}, sof: pair.sof, eol: 1'b0};
                slot[1] <= '{w: '{c: pair.cr_f, y: pair.y_odd},  sof: 1'b0,     eol: pair.eol};
            end
            unique case (st)
                PK_IDLE:   if (load) st <= PK_FIRST;
                PK_FIRST:  if (out_ready) st <= PK_SECOND;
                PK_SECOND: if (out_ready) st <= load ? PK_FIRST : PK_IDLE;
                default:   st <= PK_IDLE;
            endcase
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eol)));
    // R4
    sof_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> !in_second);
    // R6
    eol_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eol) |-> in_second);
endmodule

// File: rtl/chroma422_resampler.sv
`timescale 1ns/1ps
module chroma422_resampler
    import chroma422_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PIX_W-1:0]   in_y,
    input  logic [PIX_W-1:0]   in_cb,
    input  logic [PIX_W-1:0]   in_cr,
    input  logic               in_sof,
    input  logic               in_eol,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_sof,
    output logic               out_eol
);
    pix_t  pix;
    pair_t pair;
    logic  pair_valid;
    logic  pair_ready;

    assign pix = '{y: in_y, cb: in_cb, cr: in_cr};

    c422_pair_gather u_gather (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_pix     (pix),
        .in_sof     (in_sof),
        .in_eol     (in_eol),
        .pair_valid (pair_valid),
        .pair_ready (pair_ready),
        .pair       (pair)
    );

    c422_pair_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .pair_valid (pair_valid),
        .pair_ready (pair_ready),
        .pair       (pair),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_sof    (out_sof),
        .out_eol    (out_eol)
    );

    // R9
    pair_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && pair_ready) |=> out_valid);
endmodule

// File: tb/chroma422_resampler_test.sv
`timescale 1ns/1ps
module chroma422_resampler_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_W      = 32;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_y = '0, in_cb = '0, in_cr = '0;
    logic        in_sof = 1'b0, in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        out_sof, out_eol;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int px_sent = 0;
    int words_got = 0;
    bit rand_ready = 0;
    bit rand_gaps  = 0;
    bit done = 0;
    int stall_in = 0;
    logic [17:0] exp_q[$];
    logic [15:0] last_w [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    chroma422_resampler uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
    );

    function automatic logic [7:0] ref_tap(int l, int m, int r);
        return 8'((l + 2 * m + r + 2) / 4);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output monitor: drives out_ready, checks accepted words and stalls.
    logic        stalled = 0;
    logic [17:0] stall_val = '0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            out_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
            #1;
            if (stalled) begin
                // R7: stall holds the word
                check(out_valid && {out_sof, out_eol, out_data} == stall_val,
                      "R7 stall hold", int'({out_valid, out_sof, out_eol, out_data}),
                      int'({1'b1, stall_val}));
            end
            stalled   = out_valid && !out_ready;
            stall_val = {out_sof, out_eol, out_data};
            if (out_valid && out_ready) begin
                words_got++;
                if (exp_q.size() == 0) begin
                    check(0, "R1 unexpected word", int'(out_data), 0);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    check(out_data[7:0] == e[7:0], "R1 luma", int'(out_data[7:0]), int'(e[7:0]));
                    check(out_data[15:8] == e[15:8], "R2 chroma (edge R3, phase R4)",
                          int'(out_data[15:8]), int'(e[15:8]));
                    check({out_sof, out_eol} == e[17:16], "R6 markers",
                          int'({out_sof, out_eol}), int'(e[17:16]));
                end
                last_w[0] = last_w[1];
                last_w[1] = out_data;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (!rst && in_valid && !in_ready) stall_in++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic drive_px(logic [7:0] y, logic [7:0] cb, logic [7:0] cr, bit sof, bit eol);
        bit acc;
        if (rand_gaps) repeat ($urandom % 3) @(negedge clk);
        in_valid = 1; in_y = y; in_cb = cb; in_cr = cr; in_sof = sof; in_eol = eol;
        acc = 0;
        while (!acc) begin
            #2;
            acc = in_ready;
            @(negedge clk);
        end
        in_valid = 0; in_sof = 0; in_eol = 0;
        px_sent++;
    endtask

    // mode 0 random, 1 flat red pair pattern, 2 all 0xFF, 3 all 0x00
    task automatic send_line(int w, bit sof, int mode);
        logic [7:0] y[MAX_W], cb[MAX_W], cr[MAX_W];
        for (int i = 0; i < w; i++) begin
            case (mode)
                1: begin y[i] = (i % 2 == 0) ? 8'hF0 : 8'h5A; cb[i] = 8'h52; cr[i] = 8'h52; end
                2: begin y[i] = 8'hFF; cb[i] = 8'hFF; cr[i] = 8'hFF; end
                3: begin y[i] = 8'h00; cb[i] = 8'h00; cr[i] = 8'h00; end
                default: begin y[i] = 8'($urandom); cb[i] = 8'($urandom); cr[i] = 8'($urandom); end
            endcase
        end
        for (int k = 0; k < w / 2; k++) begin
            int l;
            logic [7:0] ecb, ecr;
            l   = (k == 0) ? 2 * k : 2 * k - 1;
            ecb = ref_tap(cb[l], cb[2*k], cb[2*k+1]);
            ecr = ref_tap(cr[l], cr[2*k], cr[2*k+1]);
            exp_q.push_back({sof && (k == 0), 1'b0, ecb, y[2*k]});
            exp_q.push_back({1'b0, (k == w/2 - 1), ecr, y[2*k+1]});
        end
        for (int i = 0; i < w; i++)
            drive_px(y[i], cb[i], cr[i], sof && (i == 0), i == w - 1);
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R8 in_ready in reset", int'(in_ready), 1);
        rst = 0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
        @(negedge clk);

        // R5: flat chroma pair words
        send_line(2, 1, 1);
        drain();
        check(last_w[0] == 16'h52F0, "R5 even word", int'(last_w[0]), 16'h52F0);
        check(last_w[1] == 16'h525A, "R5 odd word", int'(last_w[1]), 16'h525A);
        send_line(8, 0, 2);
        drain();
        check(last_w[1] == 16'hFFFF, "R5 saturated chroma", int'(last_w[1]), 16'hFFFF);
        send_line(4, 0, 3);
        drain();
        check(last_w[1] == 16'h0000, "R5 zero chroma", int'(last_w[1]), 0);

        // R9: full rate with sink always ready
        stall_in = 0;
        for (int f = 0; f < 2; f++)
            for (int ln = 0; ln < 3; ln++) send_line(16, ln == 0, 0);
        drain();
        check(stall_in == 0, "R9 full throughput", stall_in, 0);

        // Random phase with gaps and stalls; R3 edges and R4 phase per line.
        rand_ready = 1;
        rand_gaps  = 1;
        for (int f = 0; f < 40; f++) begin
            int nl;
            nl = 1 + ($urandom % 3);
            for (int ln = 0; ln < nl; ln++)
                send_line(2 * (1 + ($urandom % (MAX_W / 2))), ln == 0, 0);
        end
        send_line(2, 1, 0);
        drain();
        // R1: one word per pixel
        check(words_got == px_sent, "R1 word count", words_got, px_sent);
        check(exp_q.size() == 0, "R1 nothing outstanding", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule